// File: doc/BRIEF.md
# DMA Controller Register Front-End and Interrupt Combiner

This block is the slave register side of a multi-channel DMA engine. A simple synchronous bus (byte offset, write data, write strobe, read strobe, registered read data) reaches a 4 KB window. The window holds a small bank of global registers, a 32-byte-stride bank of per-channel registers, and eight identification words at the top. The per-channel words are driven out in flat form so that the channel engines can use them.

The channel engines report events on two per-channel pulse inputs, one for terminal count and one for error. Each pulse sets a raw flag that stays set until software writes a one to the matching bit of the clear register. The flags are masked by two enable bits that sit in each channel's own configuration word. There is no separate mask register. Three interrupt lines come out: masked error, masked terminal count, and the OR of the two.

Top module: `dmaregif_top`

## Requirements
- R1: After reset, all raw flags, all channel registers, global configuration and sync are zero, and all three interrupt outputs are low.
- R2: A channel register sits at byte offset 0x100 + 32*channel + 4*slot, with slots source=0, destination=1, link pointer=2, control=3, configuration=4. A write there is stored, and it reads back one cycle after the read strobe. It also appears on the matching flat output at bits [32*channel +: 32].
- R3: A channel access with a channel index at or above NUM_CH, or with a slot of 5 to 7, reads 0. A write to such an offset changes no register.
- R4: A one-cycle pulse on bit c of tc_set (err_set) sets bit c of the raw TC (error) flags, which read at global word 5 (word 6). The flag then holds.
- R5: A write to global word 2 (TC clear) or word 4 (error clear) clears exactly those raw flags whose write-data bit is one. The other flags are left alone.
- R6: When a set pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: Global word 1 reads the raw TC flags AND each channel's configuration bit 15. Word 3 reads the raw error flags AND configuration bit 14. Word 0 reads the OR of the two.
- R8: irq_tc is high when any masked TC bit is set, irq_err when any masked error bit is set, and irq_any is their OR. Each follows its flags with no added delay.
- R9: Global word 7 reads configuration bit 0 of each channel, placed at that channel's bit position.
- R10: Global word 12 (configuration) and word 13 (sync) store and read back 32 bits. Words 8 to 11 read 0 and ignore writes. Any other global word, including the two clear registers, reads 0.
- R11: Offsets 0xFE0 + 4*k (k = 0..7) read one identification byte in bits 7:0, with bits 31:8 zero. The bytes are 0x80 (8 channels) or 0x81 (2 channels), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset in the register window |
| bus_wdata | input | DW | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, valid the cycle after bus_rd |
| tc_set | input | NUM_CH | Terminal-count event pulses from the channel engines |
| err_set | input | NUM_CH | Error event pulses from the channel engines |
| ch_src | output | NUM_CH*DW | Source address words, one per channel |
| ch_dst | output | NUM_CH*DW | Destination address words |
| ch_lli | output | NUM_CH*DW | Link pointer words |
| ch_ctl | output | NUM_CH*DW | Control words |
| ch_cfg | output | NUM_CH*DW | Configuration words |
| glb_cfg | output | DW | Global configuration word |
| glb_sync | output | DW | Sync word |
| irq_err | output | 1 | Any masked error flag set |
| irq_tc | output | 1 | Any masked terminal-count flag set |
| irq_any | output | 1 | OR of irq_err and irq_tc |

## Verification
The bench runs the 2-channel variant so that channel indices 2 and 3 are out of range. A decoder that drops the top index bit would alias those writes onto channel 0, and the bench catches this by reading channel 0 back. It sets and clears a flag in the same cycle, where a clear-priority update would lose the event. It uses channels whose two enable bits differ, so a swapped TC/error mask shows up in the masked status and on the interrupt pins. It also clears one flag of two, which exposes a clear that wipes the whole vector. The identification bytes, the 0x81 first byte, the software-request slots and the write-only clear words are read back to expose decode holes.

// File: rtl/dmaregif_pkg.sv
package dmaregif_pkg;

  typedef enum logic [1:0] {HIT_NONE, HIT_CHAN, HIT_GLOB, HIT_ID} hit_e;

  // channel register slots (word index within a 32-byte channel block)
  localparam logic [2:0] SL_SRC = 3'd0;
  localparam logic [2:0] SL_DST = 3'd1;
  localparam logic [2:0] SL_LLI = 3'd2;
  localparam logic [2:0] SL_CTL = 3'd3;
  localparam logic [2:0] SL_CFG = 3'd4;

  // global word indices
  localparam logic [5:0] G_STAT    = 6'd0;
  localparam logic [5:0] G_TCSTAT  = 6'd1;
  localparam logic [5:0] G_TCCLR   = 6'd2;
  localparam logic [5:0] G_ERRSTAT = 6'd3;
  localparam logic [5:0] G_ERRCLR  = 6'd4;
  localparam logic [5:0] G_RAWTC   = 6'd5;
  localparam logic [5:0] G_RAWERR  = 6'd6;
  localparam logic [5:0] G_ENMAP   = 6'd7;
  localparam logic [5:0] G_GCFG    = 6'd12;
  localparam logic [5:0] G_SYNC    = 6'd13;

  // configuration word bit positions
  localparam int CFG_ON_BIT    = 0;
  localparam int CFG_ERREN_BIT = 14;
  localparam int CFG_TCEN_BIT  = 15;

  // next value of a sticky flag vector: set beats clear
  function automatic logic [7:0] flag_next(input logic [7:0] cur,
                                           input logic [7:0] set,
                                           input logic       clr_en,
                                           input logic [7:0] clr);
    logic [7:0] kept;
    kept = clr_en ? (cur & ~clr) : cur;
    return kept | set;
  endfunction

  // identification byte k of the top window
  function automatic logic [7:0] id_byte(input logic [2:0] k, input int nch);
    case (k)
      3'd0:    return (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h0A;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dmaregif_decode.sv
module dmaregif_decode
  import dmaregif_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 12
) (
  input  logic [AW-1:0] addr,
  output hit_e          kind,
  output logic [2:0]    ch_idx,
  output logic [2:0]    slot,
  output logic [5:0]    gidx,
  output logic [2:0]    id_k
);
  localparam logic [AW-1:0] ID_BASE = AW'(12'hFE0);

  assign ch_idx = addr[7:5];
  assign slot   = addr[4:2];
  assign gidx   = addr[7:2];
  assign id_k   = addr[4:2];

  always_comb begin
    kind = HIT_NONE;
    if (addr[AW-1:8] == (AW-8)'(1)) begin
      if ((32'(ch_idx) < NUM_CH) && (slot <= SL_CFG)) kind = HIT_CHAN;
    end else if (addr >= ID_BASE) begin
      kind = HIT_ID;
    end else if (addr[AW-1:8] == '0) begin
      kind = HIT_GLOB;
    end
  end
endmodule

// File: rtl/dmaregif_chan_bank.sv
module dmaregif_chan_bank
  import dmaregif_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW     = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] ch_sel,
  input  logic [2:0]      slot,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   src_q [NUM_CH],
  output logic [DW-1:0]   dst_q [NUM_CH],
  output logic [DW-1:0]   lli_q [NUM_CH],
  output logic [DW-1:0]   ctl_q [NUM_CH],
  output logic [DW-1:0]   cfg_q [NUM_CH]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (ch_sel == CH_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[c] <= '0;
        dst_q[c] <= '0;
        lli_q[c] <= '0;
        ctl_q[c] <= '0;
        cfg_q[c] <= '0;
      end else if (hit) begin
        case (slot)
          SL_SRC:  src_q[c] <= wdata;
          SL_DST:  dst_q[c] <= wdata;
          SL_LLI:  lli_q[c] <= wdata;
          SL_CTL:  ctl_q[c] <= wdata;
          SL_CFG:  cfg_q[c] <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmaregif_irq.sv
module dmaregif_irq
  import dmaregif_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic              tc_clr_en,
  input  logic              err_clr_en,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] tc_en,
  input  logic [NUM_CH-1:0] err_en,
  output logic [NUM_CH-1:0] raw_tc,
  output logic [NUM_CH-1:0] raw_err,
  output logic [NUM_CH-1:0] msk_tc,
  output logic [NUM_CH-1:0] msk_err,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);
  logic [7:0] tc_nx, err_nx;

  always_comb begin
    tc_nx  = flag_next(8'(raw_tc),  8'(tc_set),  tc_clr_en,  8'(clr_bits));
    err_nx = flag_next(8'(raw_err), 8'(err_set), err_clr_en, 8'(clr_bits));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_tc  <= '0;
      raw_err <= '0;
    end else begin
      raw_tc  <= tc_nx[NUM_CH-1:0];
      raw_err <= err_nx[NUM_CH-1:0];
    end
  end

  assign msk_tc  = raw_tc & tc_en;
  assign msk_err = raw_err & err_en;
  assign irq_tc  = |msk_tc;
  assign irq_err = |msk_err;
  assign irq_any = irq_tc | irq_err;
endmodule

// File: rtl/dmaregif_top.sv
module dmaregif_top
  import dmaregif_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW     = 32,
  parameter int AW     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]    tc_set,
  input  logic [NUM_CH-1:0]    err_set,
  output logic [NUM_CH*DW-1:0] ch_src,
  output logic [NUM_CH*DW-1:0] ch_dst,
  output logic [NUM_CH*DW-1:0] ch_lli,
  output logic [NUM_CH*DW-1:0] ch_ctl,
  output logic [NUM_CH*DW-1:0] ch_cfg,
  output logic [DW-1:0]        glb_cfg,
  output logic [DW-1:0]        glb_sync,
  output logic                 irq_err,
  output logic                 irq_tc,
  output logic                 irq_any
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  hit_e       kind;
  logic [2:0] ch_idx, slot, id_k;
  logic [5:0] gidx;

  dmaregif_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr(bus_addr), .kind(kind), .ch_idx(ch_idx), .slot(slot),
    .gidx(gidx), .id_k(id_k)
  );

  // named events for the checker
  logic acc_valid, id_hit, wr_chan, wr_glob, tc_clr_hit, err_clr_hit;
  assign acc_valid   = (kind != HIT_NONE);
  assign id_hit      = (kind == HIT_ID);
  assign wr_chan     = bus_wr && (kind == HIT_CHAN);
  assign wr_glob     = bus_wr && (kind == HIT_GLOB);
  assign tc_clr_hit  = wr_glob && (gidx == G_TCCLR);
  assign err_clr_hit = wr_glob && (gidx == G_ERRCLR);

  logic [DW-1:0] src_a [NUM_CH];
  logic [DW-1:0] dst_a [NUM_CH];
  logic [DW-1:0] lli_a [NUM_CH];
  logic [DW-1:0] ctl_a [NUM_CH];
  logic [DW-1:0] cfg_a [NUM_CH];

  dmaregif_chan_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_chan), .ch_sel(ch_idx[CH_W-1:0]),
    .slot(slot), .wdata(bus_wdata),
    .src_q(src_a), .dst_q(dst_a), .lli_q(lli_a), .ctl_q(ctl_a), .cfg_q(cfg_a)
  );

  logic [NUM_CH-1:0] tc_en, err_en, en_map;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign ch_src[c*DW +: DW] = src_a[c];
    assign ch_dst[c*DW +: DW] = dst_a[c];
    assign ch_lli[c*DW +: DW] = lli_a[c];
    assign ch_ctl[c*DW +: DW] = ctl_a[c];
    assign ch_cfg[c*DW +: DW] = cfg_a[c];
    assign tc_en[c]  = cfg_a[c][CFG_TCEN_BIT];
    assign err_en[c] = cfg_a[c][CFG_ERREN_BIT];
    assign en_map[c] = cfg_a[c][CFG_ON_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_cfg  <= '0;
      glb_sync <= '0;
    end else if (wr_glob) begin
      if (gidx == G_GCFG) glb_cfg  <= bus_wdata;
      if (gidx == G_SYNC) glb_sync <= bus_wdata;
    end
  end

  logic [NUM_CH-1:0] raw_tc, raw_err, msk_tc, msk_err;

  dmaregif_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .tc_set(tc_set), .err_set(err_set),
    .tc_clr_en(tc_clr_hit), .err_clr_en(err_clr_hit),
    .clr_bits(bus_wdata[NUM_CH-1:0]), .tc_en(tc_en), .err_en(err_en),
    .raw_tc(raw_tc), .raw_err(raw_err), .msk_tc(msk_tc), .msk_err(msk_err),
    .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  logic [DW-1:0] rd_val;
  logic [CH_W-1:0] cs;
  assign cs = ch_idx[CH_W-1:0];

  always_comb begin
    rd_val = '0;
    case (kind)
      HIT_CHAN: begin
        case (slot)
          SL_SRC:  rd_val = src_a[cs];
          SL_DST:  rd_val = dst_a[cs];
          SL_LLI:  rd_val = lli_a[cs];
          SL_CTL:  rd_val = ctl_a[cs];
          SL_CFG:  rd_val = cfg_a[cs];
          default: rd_val = '0;
        endcase
      end
      HIT_GLOB: begin
        case (gidx)
          G_STAT:    rd_val = DW'(msk_tc | msk_err);
          G_TCSTAT:  rd_val = DW'(msk_tc);
          G_ERRSTAT: rd_val = DW'(msk_err);
          G_RAWTC:   rd_val = DW'(raw_tc);
          G_RAWERR:  rd_val = DW'(raw_err);
          G_ENMAP:   rd_val = DW'(en_map);
          G_GCFG:    rd_val = glb_cfg;
          G_SYNC:    rd_val = glb_sync;
          default:   rd_val = '0;
        endcase
      end
      HIT_ID:  rd_val = DW'(id_byte(id_k, NUM_CH));
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/dmaregif_chk.sv
module dmaregif_chk #(
  parameter int NUM_CH = 8,
  parameter int DW     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [DW-1:0]        bus_wdata,
  input logic [DW-1:0]        bus_rdata,
  input logic [NUM_CH-1:0]    tc_set,
  input logic [NUM_CH-1:0]    err_set,
  input logic [NUM_CH-1:0]    raw_tc,
  input logic [NUM_CH-1:0]    raw_err,
  input logic                 tc_clr_hit,
  input logic                 err_clr_hit,
  input logic                 acc_valid,
  input logic                 id_hit,
  input logic [NUM_CH*DW-1:0] ch_cfg,
  input logic                 irq_tc,
  input logic                 irq_err
);
  AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((raw_tc & $past(tc_set)) == $past(tc_set))); // R6
  AST_ERR_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((raw_err & $past(err_set)) == $past(err_set))); // R4
  AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_set == '0) && !tc_clr_hit) |=> $stable(raw_tc)); // R4
  AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr_hit && (tc_set == '0)) |=> ((raw_tc & $past(bus_wdata[NUM_CH-1:0])) == '0)); // R5
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_hit && (err_set == '0)) |=> ((raw_err & $past(bus_wdata[NUM_CH-1:0])) == '0)); // R5
  AST_IRQ_TC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tc |-> (raw_tc != '0)); // R8
  AST_IRQ_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (raw_err != '0)); // R8
  AST_BAD_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !acc_valid) |=> $stable(ch_cfg)); // R3
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && id_hit) |=> (bus_rdata[DW-1:8] == '0)); // R11
endmodule

bind dmaregif_top dmaregif_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc_set(tc_set),
  .err_set(err_set), .raw_tc(raw_tc), .raw_err(raw_err),
  .tc_clr_hit(tc_clr_hit), .err_clr_hit(err_clr_hit), .acc_valid(acc_valid),
  .id_hit(id_hit), .ch_cfg(ch_cfg), .irq_tc(irq_tc), .irq_err(irq_err)
);

// File: tb/dmaregif_top_test.sv
`timescale 1ns/1ps
module dmaregif_top_test;
  localparam int N  = 2;
  localparam int DW = 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0] tc_set = '0, err_set = '0;
  logic [N*DW-1:0] ch_src, ch_dst, ch_lli, ch_ctl, ch_cfg;
  logic [DW-1:0] glb_cfg, glb_sync;
  logic irq_err, irq_tc, irq_any;

  always #2 clk = ~clk;

  dmaregif_top #(.NUM_CH(N), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tc_set(tc_set), .err_set(err_set),
    .ch_src(ch_src), .ch_dst(ch_dst), .ch_lli(ch_lli), .ch_ctl(ch_ctl),
    .ch_cfg(ch_cfg), .glb_cfg(glb_cfg), .glb_sync(glb_sync),
    .irq_err(irq_err), .irq_tc(irq_tc), .irq_any(irq_any)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_seen = 1'b0;

  function automatic logic [AW-1:0] chaddr(input int c, input int s);
    return AW'(12'h100 + c * 32 + s * 4);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: issue a read and post the expected value to the scoreboard
  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // monitor: compare the registered read data against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: got %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_any", {31'b0, irq_any}, 0);
    check("R1 irq_tc", {31'b0, irq_tc}, 0);
    check("R1 irq_err", {31'b0, irq_err}, 0);
    rd(12'h014, 0, "R1 raw tc");
    rd(12'h018, 0, "R1 raw err");
    rd(chaddr(1, 4), 0, "R1 ch1 cfg");
    rd(12'h030, 0, "R1 gcfg");
    rd(12'h034, 0, "R1 sync");

    // R2 channel registers
    wr(chaddr(0, 0), 32'hA5A5_0001);
    wr(chaddr(0, 2), 32'h0000_1230);
    wr(chaddr(1, 1), 32'h5A5A_0002);
    wr(chaddr(1, 3), 32'h8000_0FFF);
    rd(chaddr(0, 0), 32'hA5A5_0001, "R2 ch0 src");
    rd(chaddr(0, 2), 32'h0000_1230, "R2 ch0 lli");
    rd(chaddr(1, 1), 32'h5A5A_0002, "R2 ch1 dst");
    rd(chaddr(1, 3), 32'h8000_0FFF, "R2 ch1 ctl");
    @(negedge clk);
    check("R2 ch_src port", ch_src[31:0], 32'hA5A5_0001);
    check("R2 ch_ctl port", ch_ctl[63:32], 32'h8000_0FFF);

    // R3 out-of-range channel and unused slot
    wr(chaddr(2, 0), 32'hDEAD_BEEF);
    wr(chaddr(3, 4), 32'hFFFF_FFFF);
    wr(chaddr(0, 5), 32'h1111_1111);
    rd(chaddr(2, 0), 0, "R3 ch2 src reads 0");
    rd(chaddr(0, 5), 0, "R3 slot5 reads 0");
    rd(chaddr(0, 0), 32'hA5A5_0001, "R3 ch0 src untouched");
    rd(chaddr(1, 4), 0, "R3 ch1 cfg untouched");
    rd(chaddr(0, 4), 0, "R3 ch0 cfg untouched");

    // configure: ch0 both enables + on, ch1 TC enable only
    wr(chaddr(0, 4), 32'h0000_C001);
    wr(chaddr(1, 4), 32'h0000_8000);
    rd(12'h01C, 32'h1, "R9 enabled map");
    @(negedge clk);
    check("R2 ch_cfg port", ch_cfg[31:0], 32'h0000_C001);

    // R4 set flags
    @(negedge clk);
    tc_set = 2'b10; err_set = 2'b11;
    @(negedge clk);
    tc_set = '0; err_set = '0;
    check("R8 irq_tc", {31'b0, irq_tc}, 1);
    check("R8 irq_err", {31'b0, irq_err}, 1);
    check("R8 irq_any", {31'b0, irq_any}, 1);
    rd(12'h014, 32'h2, "R4 raw tc");
    rd(12'h018, 32'h3, "R4 raw err");
    rd(12'h004, 32'h2, "R7 masked tc");
    rd(12'h00C, 32'h1, "R7 masked err");
    rd(12'h000, 32'h3, "R7 combined");

    // R5 clear ch0 error only
    wr(12'h010, 32'h1);
    rd(12'h018, 32'h2, "R5 raw err after clear");
    rd(12'h00C, 32'h0, "R5 masked err after clear");
    @(negedge clk);
    check("R8 irq_err low", {31'b0, irq_err}, 0);
    check("R8 irq_any still high", {31'b0, irq_any}, 1);
    wr(12'h008, 32'h2);
    @(negedge clk);
    check("R8 irq_any low", {31'b0, irq_any}, 0);
    rd(12'h014, 32'h0, "R5 raw tc cleared");

    // R6 set and clear same cycle
    @(negedge clk);
    bus_addr = 12'h008; bus_wdata = 32'h1; bus_wr = 1'b1; tc_set = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; tc_set = '0;
    rd(12'h014, 32'h1, "R6 set wins");

    // R10 global config, sync, soft-request and write-only words
    wr(12'h030, 32'h0000_0001);
    wr(12'h034, 32'h0000_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h030, 32'h1, "R10 gcfg");
    rd(12'h034, 32'hFFFF, "R10 sync");
    rd(12'h020, 0, "R10 soft req reads 0");
    rd(12'h02C, 0, "R10 soft req last reads 0");
    rd(12'h008, 0, "R10 tc clear reads 0");
    rd(12'h03C, 0, "R10 unlisted reads 0");
    rd(12'h014, 32'h1, "R10 soft write leaves flags");

    // R11 identification bytes
    rd(12'hFE0, 32'h81, "R11 id0");
    rd(12'hFE4, 32'h10, "R11 id1");
    rd(12'hFEC, 32'h0A, "R11 id3");
    rd(12'hFF4, 32'hF0, "R11 id5");
    rd(12'hFFC, 32'hB1, "R11 id7");

    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule